// File: doc/BRIEF.md
# Bitplane Reload Controller

This block sits between a memory controller that hands over 16-bit bitplane words and a pixel serializer. Each load strobe pushes one word into a four-deep word queue, whatever else is going on. A 4-bit pixel counter decides when the queued words are copied in parallel to the serializer. That copy is the reload. Only the timing of the reload sets where the fetched data lands horizontally on the line.

The block does not act on the edges of the display-enable input. A line begins at the first load strobe that finds enable already high, and only from then does the counter run. It stops only when a reload happens while enable is low. The counter rate follows a registered resolution code. A resolution change during a line, or an enable window that does not match the load stream, therefore moves the reload point. It can also leave stale words in the queue for the next line.

A hardware reset always empties the queue. It clears the pixel counter only if enable is low while reset is held. Otherwise the counter keeps its value and resumes after release.

Top module: `plane_reload_ctrl`

## Requirements
- R1: Every load strobe shifts the input word into the four-word queue and discards the oldest word, whether or not a reload has happened since the previous strobe.
- R2: A line starts at the first load strobe sampled while display enable is high. Strobes with enable low start nothing. How many cycles enable was high before the strobe does not change when the first reload fires.
- R3: The pixel counter is 4 bits wide. While no line is running it stays at zero with the run flag low and produces no reload. After a start it counts ticks from zero, and the edge that completes the 16th tick raises the reload strobe for exactly one cycle.
- R4: The resolution code passes through one register before it sets the tick rate. Code 0 (low) ticks on every second clock, the first tick falling two clocks after the start edge. Codes 1 (medium), 2 and 3 tick on every clock. In low resolution the reload fires 32 clocks after the start edge. With M medium clocks (M at most 16) taken from the start of a line, the first reload fires at 32-M clocks if M is even and 31-M clocks if M is odd. Later reloads in low resolution follow every 32 clocks.
- R5: On the cycle after the reload strobe, the four queue words appear in parallel. Plane k occupies bits [16k+15:16k], and plane 0 is the oldest word. The plane outputs change at no other time.
- R6: The word-position count is cleared by every reload. It counts the load strobes since the last reload, saturating at 4.
- R7: The counter and the run flag clear only when a reload fires with enable low on that same edge. If enable goes low and returns before the next reload, counting goes on without a new line start.
- R8: Reset clears the queue, the plane outputs, the position count and the strobe. It clears the pixel counter and the run flag only if enable is low while reset is held, and holds them otherwise. Release takes two clocks, and counting then resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_i | input | 1 | Word load strobe from the memory controller |
| word_i | input | 16 | Bitplane word delivered with the load strobe |
| de_i | input | 1 | Display enable |
| res_i | input | 2 | Resolution code: 0 low, 1 medium, 2 high |
| reload_o | output | 1 | One-cycle reload strobe |
| plane_o | output | 64 | Four reloaded plane words, plane 0 in the low 16 bits |
| pix_cnt_o | output | 4 | Pixel counter value |
| cnt_run_o | output | 1 | Pixel counter enabled (line in progress) |
| word_pos_o | output | 3 | Load strobes since the last reload, saturating at 4 |

## Verification
A wrong pixel count or tick phase shows up first as a reload strobe one or more clocks early or late. That is visible at most 32 clocks after the line start. A fault in the queue order shows in the plane words on the cycle after the next strobe. A run flag that starts, stops or survives reset wrongly appears at once on the run output, and within one reload period as reloads that are missing or extra. The resolution vectors sweep the number of medium clocks across even and odd values, so a phase error of a single clock cannot hide.

// File: rtl/plane_reload_pkg.sv
package plane_reload_pkg;
  typedef enum logic [1:0] {
    RES_LOW  = 2'd0,
    RES_MED  = 2'd1,
    RES_HIGH = 2'd2,
    RES_RSVD = 2'd3
  } res_code_e;

  function automatic logic res_fast(input logic [1:0] code);
    return code != RES_LOW;
  endfunction
endpackage

// File: rtl/plane_rst_sync.sv
module plane_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/plane_pix_timer.sv
module plane_pix_timer
  import plane_reload_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_s_n,
  input  logic             load_i,
  input  logic             de_i,
  input  logic [1:0]       res_i,
  output logic             hit_o,
  output logic             strobe_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  logic [1:0]       res_q;
  logic             phase_q, phase_d;
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             strobe_q;
  logic             tick, start, hit;

  // next-state
  always_comb begin
    start   = !run_q && load_i && de_i;
    tick    = run_q && (res_fast(res_q) || phase_q);
    hit     = tick && (cnt_q == CNT_LAST);
    run_d   = run_q;
    cnt_d   = cnt_q;
    phase_d = !phase_q;
    if (start) begin
      run_d   = 1'b1;
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (tick) begin
      cnt_d = CNT_W'(cnt_q + 1'b1);
      if (hit && !de_i) begin
        run_d = 1'b0;
        cnt_d = '0;
      end
    end
  end

  // registers with plain reset
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      res_q    <= RES_LOW;
      phase_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      res_q    <= res_i;
      phase_q  <= phase_d;
      strobe_q <= hit;
    end
  end

  // counter: reset acts only while enable is low
  always_ff @(posedge clk) begin
    if (!rst_s_n) begin
      if (!de_i) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign hit_o    = hit;
  assign strobe_o = strobe_q;
  assign cnt_o    = cnt_q;
  assign run_o    = run_q;

  // R3: strobe is a single-cycle pulse
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_s_n)
    strobe_q |=> !strobe_q);
  // R3: idle counter sits at zero
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    !run_q |-> (cnt_q == '0));
  // R2: line start enables counting from zero
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!run_q && load_i && de_i) |=> (run_q && cnt_q == '0));
  // R7: reload with enable low ends the line
  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hit && !de_i) |=> !run_q);
  // R7: without such a reload the counter keeps running
  a_r7_keep: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_q && !(hit && !de_i)) |=> run_q);
  // R4: low resolution never ticks on two consecutive clocks
  a_r4_low_rate: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_q && !res_fast(res_q) && !phase_q) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/plane_word_queue.sv
module plane_word_queue #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4,
  parameter int POS_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_s_n,
  input  logic                    load_i,
  input  logic [WORD_W-1:0]       word_i,
  input  logic                    reload_evt_i,
  input  logic                    strobe_i,
  output logic [DEPTH*WORD_W-1:0] plane_o,
  output logic [POS_W-1:0]        pos_o
);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(DEPTH);

  logic [WORD_W-1:0]       stage_q [DEPTH];
  logic [DEPTH*WORD_W-1:0] flat;
  logic [DEPTH*WORD_W-1:0] plane_q;
  logic [POS_W-1:0]        pos_q, pos_d;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else if (load_i) begin
      stage_q[0] <= word_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  // plane 0 is the oldest word
  for (genvar g = 0; g < DEPTH; g++) begin : g_plane
    assign flat[g*WORD_W +: WORD_W] = stage_q[DEPTH-1-g];
  end

  always_comb begin
    pos_d = pos_q;
    if (reload_evt_i)                 pos_d = load_i ? POS_W'(1) : '0;
    else if (load_i && pos_q != POS_MAX) pos_d = POS_W'(pos_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      plane_q <= '0;
      pos_q   <= '0;
    end else begin
      if (strobe_i) plane_q <= flat;
      pos_q <= pos_d;
    end
  end

  assign plane_o = plane_q;
  assign pos_o   = pos_q;

  // R1: new word enters at the head
  a_r1_enter: assert property (@(posedge clk) disable iff (!rst_s_n)
    load_i |=> (stage_q[0] == $past(word_i)));
  // R1: the tail takes its neighbour, dropping the oldest
  a_r1_drop: assert property (@(posedge clk) disable iff (!rst_s_n)
    load_i |=> (stage_q[DEPTH-1] == $past(stage_q[DEPTH-2])));
  // R6: reload clears the position count
  a_r6_pos_clear: assert property (@(posedge clk) disable iff (!rst_s_n)
    reload_evt_i |=> (pos_q <= POS_W'(1)));
  // R5: plane outputs move only after a strobe
  a_r5_planes_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !strobe_i |=> $stable(plane_q));
endmodule

// File: rtl/plane_reload_ctrl.sv
module plane_reload_ctrl #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [WORD_W-1:0]       word_i,
  input  logic                    de_i,
  input  logic [1:0]              res_i,
  output logic                    reload_o,
  output logic [DEPTH*WORD_W-1:0] plane_o,
  output logic [CNT_W-1:0]        pix_cnt_o,
  output logic                    cnt_run_o,
  output logic [$clog2(DEPTH+1)-1:0] word_pos_o
);
  localparam int POS_W = $clog2(DEPTH + 1);

  logic rst_s_n;
  logic hit;
  logic strobe;

  plane_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  plane_pix_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_s_n  (rst_s_n),
    .load_i   (load_i),
    .de_i     (de_i),
    .res_i    (res_i),
    .hit_o    (hit),
    .strobe_o (strobe),
    .cnt_o    (pix_cnt_o),
    .run_o    (cnt_run_o)
  );

  plane_word_queue #(.WORD_W(WORD_W), .DEPTH(DEPTH), .POS_W(POS_W)) i_queue (
    .clk          (clk),
    .rst_s_n      (rst_s_n),
    .load_i       (load_i),
    .word_i       (word_i),
    .reload_evt_i (hit),
    .strobe_i     (strobe),
    .plane_o      (plane_o),
    .pos_o        (word_pos_o)
  );

  assign reload_o = strobe;

  // R5: strobe and a fresh position count go together
  a_r5_strobe_pos: assert property (@(posedge clk) disable iff (!rst_s_n)
    reload_o |-> (word_pos_o <= POS_W'(1)));
endmodule

// File: tb/test_plane_reload_ctrl.sv
module test_plane_reload_ctrl;
  localparam int W  = 16;
  localparam int D  = 4;
  localparam int CW = 4;
  localparam int PW = 3;
  localparam int NV = 7;
  // vectors: medium clocks from line start, code used, expected first reload offset
  localparam int V_MED [NV] = '{0, 1, 2, 5, 10, 16, 8};
  localparam int V_RES [NV] = '{0, 1, 1, 1, 1, 1, 2};
  localparam int V_OFF [NV] = '{32, 30, 30, 26, 22, 16, 24};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, load_i, de_i;
  logic [W-1:0]  word_i;
  logic [1:0]    res_i;
  logic          reload_o, cnt_run_o;
  logic [D*W-1:0] plane_o;
  logic [CW-1:0] pix_cnt_o;
  logic [PW-1:0] word_pos_o;

  plane_reload_ctrl i_plane_reload_ctrl (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .word_i(word_i), .de_i(de_i),
    .res_i(res_i), .reload_o(reload_o), .plane_o(plane_o),
    .pix_cnt_o(pix_cnt_o), .cnt_run_o(cnt_run_o), .word_pos_o(word_pos_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic de);
    rst_n = 1'b0; de_i = de; load_i = 1'b0; res_i = 2'd0; word_i = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] base;
    int extra;
    int held;
    bit seen;
    rst_n = 1'b0; load_i = 1'b0; de_i = 1'b0; res_i = 2'd0; word_i = '0;
    @(negedge clk);
    do_reset(1'b0);

    // reset state (R8)
    check(reload_o == 1'b0, "R8", "strobe after reset", reload_o, 0);
    check(cnt_run_o == 1'b0 && pix_cnt_o == '0, "R8", "counter after reset", pix_cnt_o, 0);
    check(plane_o == '0, "R8", "planes after reset", plane_o, 0);
    check(word_pos_o == '0, "R8", "position after reset", word_pos_o, 0);

    // vector table: resolution windows (R4, R5, R6, R3)
    for (int v = 0; v < NV; v++) begin
      do_reset(1'b0);
      base  = W'(16'h1000 * (v + 1));
      extra = 0;
      for (int k = 0; k <= V_OFF[v] + 33; k++) begin
        load_i = (k == 0 || k == 2 || k == 4 || k == 6);
        word_i = W'(base + W'(k / 2));
        res_i  = (k < V_MED[v]) ? 2'(V_RES[v]) : 2'd0;
        de_i   = 1'b1;
        step();
        if (k == V_OFF[v] || k == V_OFF[v] + 32)
          check(reload_o == 1'b1, "R4", $sformatf("reload at +%0d vec %0d", k, v), reload_o, 1);
        else if (reload_o)
          extra++;
        if (k == V_OFF[v])
          check(word_pos_o == '0, "R6", "position cleared by reload", word_pos_o, 0);
        if (k == V_OFF[v] + 1)
          for (int p = 0; p < D; p++)
            check(plane_o[p*W +: W] == W'(base + W'(p)), "R5",
                  $sformatf("plane %0d vec %0d", p, v), plane_o[p*W +: W], base + W'(p));
      end
      load_i = 1'b0;
      check(extra == 0, "R3", $sformatf("unexpected reloads vec %0d", v), extra, 0);
    end

    // directed: loads with enable low, late start, queue overflow, stop rules
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) begin
      load_i = 1'b1; word_i = W'(16'hC000 + i); de_i = 1'b0;
      step();
    end
    load_i = 1'b0;
    check(cnt_run_o == 1'b0, "R2", "loads with enable low start nothing", cnt_run_o, 0);
    check(word_pos_o == 3'd4, "R6", "position saturates", word_pos_o, 4);
    de_i = 1'b1;
    repeat (10) step();
    check(cnt_run_o == 1'b0 && pix_cnt_o == '0, "R3", "no count before first load",
          pix_cnt_o, 0);
    extra = 0;
    for (int k = 0; k <= 130; k++) begin
      load_i = (k == 0);
      word_i = 16'hC005;
      de_i   = !((k >= 40 && k <= 50) || k >= 90);
      step();
      if (k == 0) check(cnt_run_o == 1'b1 && pix_cnt_o == '0, "R2", "start at first load",
                        pix_cnt_o, 0);
      if (k == 1) check(pix_cnt_o == 4'd0, "R4", "no tick first low clock", pix_cnt_o, 0);
      if (k == 2) check(pix_cnt_o == 4'd1, "R4", "tick second low clock", pix_cnt_o, 1);
      if (k == 32 || k == 64 || k == 96)
        check(reload_o == 1'b1, "R2", $sformatf("reload at +%0d", k), reload_o, 1);
      else if (reload_o) extra++;
      if (k == 33)
        for (int p = 0; p < D; p++)
          check(plane_o[p*W +: W] == W'(16'hC002 + p), "R1",
                $sformatf("oldest dropped plane %0d", p), plane_o[p*W +: W], 16'hC002 + p);
      if (k == 64) check(cnt_run_o == 1'b1, "R7", "enable back before reload keeps run",
                         cnt_run_o, 1);
      if (k == 96) check(cnt_run_o == 1'b0 && pix_cnt_o == '0, "R7",
                         "reload with enable low stops", pix_cnt_o, 0);
    end
    check(extra == 0, "R3", "no reload after stop", extra, 0);

    // reset with enable high mid-line holds the counter (R8)
    do_reset(1'b0);
    load_i = 1'b1; word_i = 16'hE000; de_i = 1'b1;
    step();
    load_i = 1'b0;
    repeat (10) step();
    held = int'(pix_cnt_o);
    check(held == 5, "R8", "count before reset", held, 5);
    rst_n = 1'b0;
    repeat (3) step();
    check(cnt_run_o == 1'b1 && int'(pix_cnt_o) == held, "R8", "counter held with enable high",
          pix_cnt_o, held);
    check(plane_o == '0 && word_pos_o == '0, "R8", "queue side cleared", plane_o, 0);
    rst_n = 1'b1;
    step();
    check(int'(pix_cnt_o) == held, "R8", "counter held during release", pix_cnt_o, held);
    seen = 1'b0;
    for (int k = 0; k < 64 && !seen; k++) begin
      step();
      seen = reload_o;
    end
    check(seen, "R8", "counting resumes after release", seen, 1);
    step();
    check(plane_o == '0, "R8", "cleared queue reloaded", plane_o, 0);

    // reset with enable low clears the counter (R8)
    do_reset(1'b0);
    load_i = 1'b1; de_i = 1'b1;
    step();
    load_i = 1'b0;
    repeat (10) step();
    rst_n = 1'b0; de_i = 1'b0;
    repeat (3) step();
    check(cnt_run_o == 1'b0 && pix_cnt_o == '0, "R8", "counter cleared with enable low",
          pix_cnt_o, 0);
    rst_n = 1'b1;
    extra = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (reload_o) extra++;
    end
    check(extra == 0, "R8", "no reload after clearing reset", extra, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule